// File: doc/BRIEF.md
# Transmit Packet Memory Reader

This block takes a transmit packet that host software has already placed in a 16-bit-wide packet RAM and turns it into a byte stream for a MAC transmitter. A one-cycle start command carries the word address where the packet begins. The block first reads the length word that sits one word above that base. It then reads the final word of the packet, whose high byte is the per-frame control byte. Last, it streams the data words that begin two words above the base. Each word goes out low byte first on a valid/ready interface. A last marker flags the final byte. An append-CRC flag is held for the whole frame.

The stored length counts bytes. It covers the status word, the length word, the data and the control word. Its lowest bit is always taken as zero. The control byte decides two things: whether the low byte of the final word is one more data byte, and, when the MAC is set up to suppress its automatic CRC, whether this frame still gets one. Frame contents, source address included, pass through unchanged. The block inserts no bytes and changes none. A length that is too small or too large stops the command with a one-cycle error pulse and sends nothing.

Top module: `txFrameReader`

## Requirements
- R1: A start command is taken only while `busy` is low. In the same cycle the block issues a RAM read of word address `startAddr + 1`, the length word.
- R2: Bit 0 of the stored length is treated as zero whatever its value, so 21 behaves exactly like 20.
- R3: If the masked length L is below 6 or above 1536, `errPulse` is high for exactly one cycle, no byte is sent, and `busy` falls.
- R4: The control byte is the high byte of word `startAddr + L/2 - 1`. Its bit 5 (word bit 13) is ODD and its bit 4 (word bit 12) is CRC. All other bits of the control byte are ignored.
- R5: Data is read from word `startAddr + 2` upward and sent low byte then high byte. L-6 bytes are sent when ODD is clear and L-5 when ODD is set. With ODD set, the extra final byte is the low byte of the control word.
- R6: `outLast` is high on the final byte of a frame and on no other byte.
- R7: When `noCrcMode` is 0, `outAppendCrc` is 1. When `noCrcMode` is 1, it equals the CRC control bit. It stays constant for every byte of a frame.
- R8: With `outReady` held high, bytes leave on consecutive cycles from the first byte to the last.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` keep their values in the next cycle.
- R10: L = 6 with ODD clear gives a frame of zero bytes. The block returns to idle without an error. L = 6 with ODD set gives exactly one byte.
- R11: A start command that arrives while `busy` is high has no effect on the frame in progress and does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | One-cycle start command |
| startAddr | input | ADDR_W | Word address of the packet base |
| noCrcMode | input | 1 | MAC configured to suppress automatic CRC |
| busy | output | 1 | A command is in progress |
| errPulse | output | 1 | One-cycle pulse on an illegal length |
| memRdEn | output | 1 | Packet RAM read enable |
| memRdAddr | output | ADDR_W | Packet RAM word address |
| memRdData | input | 16 | Read data, valid one cycle after the enable |
| outValid | output | 1 | Byte available |
| outReady | input | 1 | Transmitter accepts the byte |
| outData | output | 8 | Frame byte |
| outLast | output | 1 | Final byte of the frame |
| outAppendCrc | output | 1 | Transmitter must append a CRC to this frame |

## Verification
Any fault in the two-word buffer or in the byte-lane select shows on `outData`. The stream then drifts from the expected ramp of byte values, and the check catches this at the first wrong byte, within one word of the fault. A miscounted length or remaining-byte counter appears at the frame's end. The byte total is then wrong, or `outLast` marks the wrong byte, and the control FSM either ends early or hangs in its busy state. A fault in the prefetch accounting shows up as lost throughput: under steady ready the span from first to last byte grows by at least one cycle.

// File: rtl/txrd_pkg.sv
package txrd_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic capCount;  // memRdData holds the length word
    logic capCtl;    // memRdData holds the control word
    logic loadWord;  // memRdData holds a stream word
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CNT_WAIT,
    ST_CTL_WAIT,
    ST_STREAM
  } rdState_t;

endpackage

// File: rtl/txrdDatapath.sv
module txrdDatapath
  import txrd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MAX_COUNT = 1536,
  parameter int ODD_BIT   = 5,
  parameter int CRC_BIT   = 4,
  localparam int BL_W     = $clog2(MAX_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              noCrcMode,
  input  logic              outReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              outAppendCrc,
  output logic              countBad,
  output logic [ADDR_W-1:0] ctlWordOff,
  output logic [BL_W-1:0]   fetchWords,
  output logic [1:0]        bufCount,
  output logic              streamDone
);

  localparam int MIN_COUNT = 6;
  localparam int HDR_WORDS = 3;  // status word, length word, control word

  logic [WORD_W-1:0] maskedCnt;
  logic              ctlOdd;
  logic              ctlCrc;

  logic [BL_W-1:0]   countReg;
  logic [BL_W-1:0]   bytesLeft;
  logic              appendReg;

  logic [WORD_W-1:0] curWord, nxtWord;
  logic              curV, nxtV;
  logic              hiSel;
  logic              fire, pop;

  // Length decode straight from the read port
  always_comb begin
    maskedCnt  = {memRdData[WORD_W-1:1], 1'b0};
    countBad   = (maskedCnt < WORD_W'(MIN_COUNT)) || (maskedCnt > WORD_W'(MAX_COUNT));
    ctlWordOff = ADDR_W'(maskedCnt[WORD_W-1:1]) - ADDR_W'(1);
    ctlOdd     = memRdData[BYTE_W + ODD_BIT];
    ctlCrc     = memRdData[BYTE_W + CRC_BIT];
    fetchWords = BL_W'(countReg[BL_W-1:1]) - BL_W'(HDR_WORDS) + BL_W'(ctlOdd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg  <= '0;
      bytesLeft <= '0;
      appendReg <= 1'b1;
    end else begin
      if (strobe.capCount)
        countReg <= maskedCnt[BL_W-1:0];
      if (strobe.capCtl) begin
        bytesLeft <= countReg - BL_W'(MIN_COUNT) + BL_W'(ctlOdd);
        appendReg <= noCrcMode ? ctlCrc : 1'b1;
      end else if (fire) begin
        bytesLeft <= bytesLeft - BL_W'(1);
      end
    end
  end

  // Output byte lane
  always_comb begin
    outValid     = curV;
    outData      = hiSel ? curWord[WORD_W-1:BYTE_W] : curWord[BYTE_W-1:0];
    outLast      = curV && (bytesLeft == BL_W'(1));
    outAppendCrc = appendReg;
    fire         = curV && outReady;
    pop          = fire && (hiSel || (bytesLeft == BL_W'(1)));
    bufCount     = 2'(curV) + 2'(nxtV);
    streamDone   = (bytesLeft == '0);
  end

  // Two-entry word buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curV    <= 1'b0;
      nxtV    <= 1'b0;
      curWord <= '0;
      nxtWord <= '0;
      hiSel   <= 1'b0;
    end else begin
      unique case ({pop, strobe.loadWord})
        2'b11: begin
          if (nxtV) begin
            curWord <= nxtWord;
            nxtWord <= memRdData;
          end else begin
            curWord <= memRdData;
          end
        end
        2'b10: begin
          if (nxtV) begin
            curWord <= nxtWord;
            nxtV    <= 1'b0;
          end else begin
            curV <= 1'b0;
          end
        end
        2'b01: begin
          if (!curV) begin
            curWord <= memRdData;
            curV    <= 1'b1;
          end else begin
            nxtWord <= memRdData;
            nxtV    <= 1'b1;
          end
        end
        default: ;
      endcase
      if (fire)
        hiSel <= !pop;
    end
  end

endmodule

// File: rtl/txrdCtrl.sv
module txrdCtrl
  import txrd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MAX_COUNT = 1536,
  localparam int BL_W     = $clog2(MAX_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              countBad,
  input  logic [ADDR_W-1:0] ctlWordOff,
  input  logic [BL_W-1:0]   fetchWords,
  input  logic [1:0]        bufCount,
  input  logic              streamDone,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              errPulse,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr
);

  localparam int DATA_OFF = 2;
  localparam int CNT_OFF  = 1;
  localparam int BUF_SLOTS = 2;

  rdState_t          state;
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] fetchAddr;
  logic [BL_W-1:0]   fetchLeft;
  logic              inFlight;
  logic              issue;

  always_comb begin
    issue = (state == ST_STREAM) && (fetchLeft != '0) &&
            ((3'(bufCount) + 3'(inFlight)) < 3'(BUF_SLOTS));
    strobe          = '0;
    strobe.loadWord = inFlight;
    memRdEn         = 1'b0;
    memRdAddr       = fetchAddr;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          memRdEn   = 1'b1;
          memRdAddr = startAddr + ADDR_W'(CNT_OFF);
        end
      end
      ST_CNT_WAIT: begin
        strobe.capCount = 1'b1;
        if (!countBad) begin
          memRdEn   = 1'b1;
          memRdAddr = baseReg + ctlWordOff;
        end
      end
      ST_CTL_WAIT: strobe.capCtl = 1'b1;
      ST_STREAM:   memRdEn = issue;
      default: ;
    endcase
    busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      baseReg   <= '0;
      fetchAddr <= '0;
      fetchLeft <= '0;
      inFlight  <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      errPulse <= 1'b0;
      inFlight <= issue;
      unique case (state)
        ST_IDLE: begin
          if (startValid) begin
            baseReg <= startAddr;
            state   <= ST_CNT_WAIT;
          end
        end
        ST_CNT_WAIT: begin
          if (countBad) begin
            errPulse <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            state <= ST_CTL_WAIT;
          end
        end
        ST_CTL_WAIT: begin
          fetchLeft <= fetchWords;
          fetchAddr <= baseReg + ADDR_W'(DATA_OFF);
          state     <= ST_STREAM;
        end
        ST_STREAM: begin
          if (issue) begin
            fetchAddr <= fetchAddr + ADDR_W'(1);
            fetchLeft <= fetchLeft - BL_W'(1);
          end
          if (streamDone && (fetchLeft == '0) && !inFlight)
            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txFrameReader.sv
module txFrameReader
  import txrd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MAX_COUNT = 1536,
  parameter int ODD_BIT   = 5,
  parameter int CRC_BIT   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              noCrcMode,
  output logic              busy,
  output logic              errPulse,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [15:0]       memRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic              outAppendCrc
);

  localparam int BL_W = $clog2(MAX_COUNT + 1);

  dpStrobe_t         strobe;
  logic              countBad;
  logic [ADDR_W-1:0] ctlWordOff;
  logic [BL_W-1:0]   fetchWords;
  logic [1:0]        bufCount;
  logic              streamDone;

  txrdCtrl #(.ADDR_W(ADDR_W), .MAX_COUNT(MAX_COUNT)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startAddr  (startAddr),
    .countBad   (countBad),
    .ctlWordOff (ctlWordOff),
    .fetchWords (fetchWords),
    .bufCount   (bufCount),
    .streamDone (streamDone),
    .strobe     (strobe),
    .busy       (busy),
    .errPulse   (errPulse),
    .memRdEn    (memRdEn),
    .memRdAddr  (memRdAddr)
  );

  txrdDatapath #(.ADDR_W(ADDR_W), .MAX_COUNT(MAX_COUNT), .ODD_BIT(ODD_BIT), .CRC_BIT(CRC_BIT)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .memRdData    (memRdData),
    .noCrcMode    (noCrcMode),
    .outReady     (outReady),
    .outValid     (outValid),
    .outData      (outData),
    .outLast      (outLast),
    .outAppendCrc (outAppendCrc),
    .countBad     (countBad),
    .ctlWordOff   (ctlWordOff),
    .fetchWords   (fetchWords),
    .bufCount     (bufCount),
    .streamDone   (streamDone)
  );

endmodule

// File: rtl/txrdChecker.sv
module txrdChecker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [ADDR_W-1:0] startAddr,
  input logic              busy,
  input logic              errPulse,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outData,
  input logic              outLast,
  input logic              outAppendCrc
);

  // R1: an accepted start reads the length word at once
  a_r1_len_read: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |-> (memRdEn && memRdAddr == startAddr + ADDR_W'(1)));

  // R9: a stalled byte is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R6: nothing follows the final byte in the next cycle
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);

  // R7: CRC flag constant within a frame
  a_r7_crc_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> $stable(outAppendCrc));

  // R3: error is a single pulse and sends no byte
  a_r3_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
  a_r3_err_silent: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!outValid && !busy));

endmodule

bind txFrameReader txrdChecker #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startValid   (startValid),
  .startAddr    (startAddr),
  .busy         (busy),
  .errPulse     (errPulse),
  .memRdEn      (memRdEn),
  .memRdAddr    (memRdAddr),
  .outValid     (outValid),
  .outReady     (outReady),
  .outData      (outData),
  .outLast      (outLast),
  .outAppendCrc (outAppendCrc)
);

// File: tb/test_txFrameReader.sv
`timescale 1ns/1ps
module test_txFrameReader;

  localparam int ADDR_W = 10;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              noCrcMode = 1'b0;
  logic              busy, errPulse, memRdEn;
  logic [ADDR_W-1:0] memRdAddr;
  logic [15:0]       memRdData = '0;
  logic              outValid, outLast, outAppendCrc;
  logic              outReady = 1'b1;
  logic [7:0]        outData;

  logic [15:0] mem [MEM_WORDS];

  int total = 0, failed = 0, cyc = 0;
  int readyMode = 0;
  logic [7:0] lfsr = 8'hA5;

  // capture state
  int   capN, firstFire, lastFire, errSeen, holdViol, crcBad;
  logic [7:0] capData [2048];
  logic       capLast [2048];
  logic       expCrcG;
  logic       holdPend = 1'b0;
  logic [7:0] heldData;
  logic       heldLast;

  always #2 clk = ~clk;  // 250 MHz

  txFrameReader #(.ADDR_W(ADDR_W)) i_txFrameReader (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .noCrcMode(noCrcMode), .busy(busy), .errPulse(errPulse), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .outAppendCrc(outAppendCrc)
  );

  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = (readyMode == 0) ? 1'b1 : lfsr[0];
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++; failed++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (holdPend && (!outValid || outData != heldData || outLast != heldLast))
        holdViol++;
      holdPend = outValid && !outReady;
      heldData = outData;
      heldLast = outLast;
      if (outValid && outReady) begin
        if (capN < 2048) begin
          capData[capN] = outData;
          capLast[capN] = outLast;
        end
        if (outAppendCrc != expCrcG) crcBad++;
        if (capN == 0) firstFire = cyc;
        lastFire = cyc;
        capN++;
      end
      if (errPulse) errSeen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCap();
    capN = 0; firstFire = 0; lastFire = 0; errSeen = 0; holdViol = 0; crcBad = 0;
  endtask

  task automatic pulseStart(input int base);
    @(posedge clk); #1;
    startAddr = ADDR_W'(base);
    startValid = 1'b1;
    @(posedge clk); #1;
    startValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (12) @(negedge clk);
  endtask

  // Expected byte k of a frame at base: (seed + k) mod 256
  task automatic runFrame(input int base, input int cntW, input bit odd, input bit crc,
                          input bit noCrc, input int rdyMode, input bit extraStart,
                          input string tag);
    int cnt, nData, expN, badIdx;
    logic [7:0] seed;
    cnt   = cntW & ~1;
    nData = cnt / 2 - 3;
    expN  = cnt - 6 + int'(odd);
    seed  = 8'(base) ^ 8'h5A;
    mem[base]     = 16'hBEEF;
    mem[base + 1] = 16'(cntW);
    for (int i = 0; i < nData; i++)
      mem[base + 2 + i] = {8'(seed + 8'(2*i + 1)), 8'(seed + 8'(2*i))};
    mem[base + 2 + nData] = {8'(8'h0C | (8'(odd) << 5) | (8'(crc) << 4)), 8'(seed + 8'(2*nData))};
    clearCap();
    readyMode = rdyMode;
    noCrcMode = noCrc;
    expCrcG   = noCrc ? crc : 1'b1;
    pulseStart(base);
    if (extraStart) begin
      repeat (4) @(posedge clk);
      chk(busy == 1'b1, "R11", {tag, " busy before second start"}, int'(busy), 1);
      pulseStart(600);
    end
    waitIdle();
    chk(capN == expN, "R5", {tag, " byte count"}, capN, expN);
    badIdx = -1;
    for (int k = 0; k < expN && k < capN && k < 2048; k++)
      if (badIdx < 0 && capData[k] != 8'(seed + 8'(k))) badIdx = k;
    if (badIdx >= 0)
      chk(1'b0, "R5", {tag, " data byte"}, int'(capData[badIdx]), int'(8'(seed + 8'(badIdx))));
    else
      chk(1'b1, "R5", {tag, " data"}, 0, 0);
    badIdx = -1;
    for (int k = 0; k < capN && k < 2048; k++)
      if (badIdx < 0 && capLast[k] != (k == expN - 1)) badIdx = k;
    chk(badIdx < 0, "R6", {tag, " last marker position"}, badIdx, -1);
    if (expN > 0)
      chk(crcBad == 0, "R7", {tag, " append-CRC flag mismatches"}, crcBad, 0);
    chk(errSeen == 0, "R3", {tag, " no error on legal length"}, errSeen, 0);
    chk(holdViol == 0, "R9", {tag, " stalled byte changed"}, holdViol, 0);
    if (rdyMode == 0 && expN > 1)
      chk(lastFire - firstFire == expN - 1, "R8", {tag, " cycles first to last byte"},
          lastFire - firstFire, expN - 1);
    readyMode = 0;
  endtask

  task automatic errFrame(input int base, input int cntW, input string tag);
    mem[base + 1] = 16'(cntW);
    clearCap();
    pulseStart(base);
    waitIdle();
    chk(errSeen == 1, "R3", {tag, " error pulses"}, errSeen, 1);
    chk(capN == 0, "R3", {tag, " bytes sent"}, capN, 0);
    chk(busy == 1'b0, "R3", {tag, " busy after error"}, int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'(i * 7 + 3);
    mem[601] = 16'd10;  // a frame the ignored start would have sent
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && outValid == 1'b0, "R1", "idle after reset", int'(busy) + int'(outValid), 0);
    chk(memRdEn == 1'b0 && errPulse == 1'b0, "R3", "no read or error after reset",
        int'(memRdEn) + int'(errPulse), 0);

    runFrame(16,  20,   1'b0, 1'b1, 1'b0, 0, 1'b0, "even frame R1 R4");
    runFrame(100, 21,   1'b1, 1'b0, 1'b1, 0, 1'b0, "odd count bit R2");
    runFrame(140, 64,   1'b1, 1'b1, 1'b1, 1, 1'b0, "throttled R9 R7");
    runFrame(60,  40,   1'b0, 1'b0, 1'b0, 0, 1'b0, "crc forced R7");
    runFrame(200, 1536, 1'b1, 1'b0, 1'b0, 0, 1'b0, "max length R8");
    runFrame(20,  6,    1'b0, 1'b0, 1'b0, 0, 1'b0, "empty R10");
    runFrame(30,  7,    1'b1, 1'b1, 1'b1, 0, 1'b0, "one byte R10");
    runFrame(300, 40,   1'b1, 1'b0, 1'b0, 1, 1'b1, "start while busy R11");
    errFrame(400, 4,      "short length");
    errFrame(410, 1538,   "long length");
    errFrame(420, 16'hFFFF, "huge length");
    runFrame(430, 12,   1'b0, 1'b1, 1'b1, 0, 1'b0, "after errors R1");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule